// File: doc/BRIEF.md
# Out-of-order DRAM read command scheduler

This block sits in a memory controller between the request side and a multi-bank SDRAM command bus. Read requests arrive with a bank, row, column and ID, and wait in a small queue. Each clock the scheduler looks at every queued request, works out which command that request needs next, and issues at most one command: ACTIVATE to open a row, READ to fetch a column from the open row, or PRECHARGE to close a row that is in the way.

The pick is first-ready, first-come-first-served. Only requests whose bank timing windows have expired are candidates. Among them, READs (row hits) beat ACTIVATE and PRECHARGE, and inside each group the request that arrived first wins. Rows stay open after a READ until some request for a different row in that bank precharges them. A request leaves the queue when its READ issues. Its ID appears on the completion port a fixed CAS latency later.

Top module: `dram_sched_frfcfs`

## Requirements
- R1: While reset is held and on leaving it, `cmd_valid_o` and `done_valid_o` are 0, `req_ready_o` is 1, and every bank is treated as closed.
- R2: A request to a closed bank gets ACTIVATE (`cmd_type_o` = 2'b01) carrying its row. Its READ (`cmd_type_o` = 2'b10) comes no earlier than T_RCD (default 2) cycles after that ACTIVATE.
- R3: A request whose row is already open in its bank is served by a READ alone, with no new ACTIVATE.
- R4: A request to a bank open on another row gets PRECHARGE (`cmd_type_o` = 2'b11), then ACTIVATE, then READ. PRECHARGE waits T_RCD cycles after the ACTIVATE that opened the row. The next ACTIVATE waits T_RP (default 2) cycles after the PRECHARGE.
- R5: Among eligible requests, any READ beats any ACTIVATE or PRECHARGE. Within a group, the request accepted earliest wins.
- R6: Two ACTIVATEs to the same bank are at least T_RC (default 6) cycles apart.
- R7: `done_valid_o` pulses with `done_id_o` equal to the request's ID exactly T_CL (default 2) cycles after the cycle in which that request's READ is on the command bus.
- R8: The queue holds QDEPTH (default 6) requests. `req_ready_o` is 0 exactly when it is full. A request is accepted on a clock edge where both `req_valid_i` and `req_ready_o` are 1. A request offered while `req_ready_o` is 0 is dropped and never completes.
- R9: At most one command is on the bus per cycle, and it is registered. Banks are timed independently, so an ACTIVATE to one bank may issue inside another bank's T_RC window. When `cmd_valid_o` is 1, `cmd_bank_o`, `cmd_row_o` and `cmd_col_o` carry the selected request's fields. When `cmd_valid_o` is 0, `cmd_type_o` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Read request offered |
| req_bank_i | input | BANK_W | Request bank |
| req_row_i | input | ROW_W | Request row |
| req_col_i | input | COL_W | Request column |
| req_id_i | input | ID_W | Request ID |
| req_ready_o | output | 1 | Queue has room |
| cmd_valid_o | output | 1 | Command on bus this cycle |
| cmd_type_o | output | 2 | 00 none, 01 ACTIVATE, 10 READ, 11 PRECHARGE |
| cmd_bank_o | output | BANK_W | Target bank |
| cmd_row_o | output | ROW_W | Row of the selected request |
| cmd_col_o | output | COL_W | Column of the selected request |
| done_valid_o | output | 1 | A read completes |
| done_id_o | output | ID_W | ID of the completing read |

## Verification
The bench targets three reordering cases.

- Two hits to the same row with a conflicting request queued between them. A scheduler that ignored row-hit priority would precharge in the middle and reorder the completions wrongly.
- A conflicting request that becomes eligible while a hit is still waiting out T_RCD. A scheduler that checked no PRECHARGE window would close the row before its first READ.
- Back-to-back conflicts in one bank, which expose an ACTIVATE issued inside T_RC or T_RP.

A burst that holds `req_valid_i` high past a full queue catches an overflowing queue. It would issue reads for dropped requests and end with more completions than acceptances.

// File: rtl/dram_sched_pkg.sv
package dram_sched_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_ACT = 2'b01,
    CMD_RD  = 2'b10,
    CMD_PRE = 2'b11
  } cmd_e;
endpackage

// File: rtl/dram_req_queue.sv
// Age-ordered request store: slot 0 is oldest; a pop collapses the slots above it.
module dram_req_queue #(
  parameter int DEPTH  = 6,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int ID_W   = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          push_i,
  input  logic [BANK_W-1:0]             push_bank_i,
  input  logic [ROW_W-1:0]              push_row_i,
  input  logic [COL_W-1:0]              push_col_i,
  input  logic [ID_W-1:0]               push_id_i,
  input  logic                          pop_i,
  input  logic [IDX_W-1:0]              pop_idx_i,
  output logic [DEPTH-1:0]              vld_o,
  output logic [DEPTH-1:0][BANK_W-1:0]  bank_o,
  output logic [DEPTH-1:0][ROW_W-1:0]   row_o,
  output logic [DEPTH-1:0][COL_W-1:0]   col_o,
  output logic [DEPTH-1:0][ID_W-1:0]    id_o,
  output logic                          full_o
);
  logic [DEPTH-1:0]             vld_q, vld_n;
  logic [DEPTH-1:0][BANK_W-1:0] bank_q, bank_n;
  logic [DEPTH-1:0][ROW_W-1:0]  row_q, row_n;
  logic [DEPTH-1:0][COL_W-1:0]  col_q, col_n;
  logic [DEPTH-1:0][ID_W-1:0]   id_q, id_n;
  logic [CNT_W-1:0]             cnt_q, cnt_n, wpos;

  always_comb begin
    vld_n  = vld_q;
    bank_n = bank_q;
    row_n  = row_q;
    col_n  = col_q;
    id_n   = id_q;
    if (pop_i) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (IDX_W'(i) >= pop_idx_i) begin
          vld_n[i]  = vld_q[i+1];
          bank_n[i] = bank_q[i+1];
          row_n[i]  = row_q[i+1];
          col_n[i]  = col_q[i+1];
          id_n[i]   = id_q[i+1];
        end
      end
      vld_n[DEPTH-1] = 1'b0;
    end
    wpos = cnt_q - CNT_W'(pop_i);
    if (push_i) begin
      vld_n[wpos]  = 1'b1;
      bank_n[wpos] = push_bank_i;
      row_n[wpos]  = push_row_i;
      col_n[wpos]  = push_col_i;
      id_n[wpos]   = push_id_i;
    end
    cnt_n = wpos + CNT_W'(push_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      id_q   <= '0;
      cnt_q  <= '0;
    end else begin
      vld_q  <= vld_n;
      bank_q <= bank_n;
      row_q  <= row_n;
      col_q  <= col_n;
      id_q   <= id_n;
      cnt_q  <= cnt_n;
    end
  end

  assign vld_o  = vld_q;
  assign bank_o = bank_q;
  assign row_o  = row_q;
  assign col_o  = col_q;
  assign id_o   = id_q;
  assign full_o = (cnt_q == CNT_W'(DEPTH));

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R5
  pop_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> vld_q[pop_idx_i]);
  // R5
  age_packed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({1'b0, vld_q} + {{DEPTH{1'b0}}, 1'b1}) == 1);
endmodule

// File: rtl/dram_bank_state.sv
// Open-row tracking and timing windows of one bank.
module dram_bank_state #(
  parameter int ROW_W = 4,
  parameter int T_RCD = 2,
  parameter int T_RP  = 2,
  parameter int T_RC  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             rd_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             col_ok_o,
  output logic             act_ok_o
);
  localparam int MAX_A = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int MAX_T = (MAX_A > T_RC) ? MAX_A : T_RC;
  localparam int TW    = $clog2(MAX_T + 1);
  localparam int GAP_W = 8;

  logic             open_q;
  logic [ROW_W-1:0] row_q;
  logic [TW-1:0]    rcd_cnt_q, rp_cnt_q, rc_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q    <= 1'b0;
      row_q     <= '0;
      rcd_cnt_q <= '0;
      rp_cnt_q  <= '0;
      rc_cnt_q  <= '0;
    end else begin
      if (act_i) begin
        open_q <= 1'b1;
        row_q  <= row_i;
      end else if (pre_i) begin
        open_q <= 1'b0;
      end
      rcd_cnt_q <= act_i ? TW'(T_RCD - 1) : (rcd_cnt_q != '0 ? rcd_cnt_q - 1'b1 : '0);
      rc_cnt_q  <= act_i ? TW'(T_RC - 1)  : (rc_cnt_q  != '0 ? rc_cnt_q  - 1'b1 : '0);
      rp_cnt_q  <= pre_i ? TW'(T_RP - 1)  : (rp_cnt_q  != '0 ? rp_cnt_q  - 1'b1 : '0);
    end
  end

  assign open_o   = open_q;
  assign row_o    = row_q;
  assign col_ok_o = (rcd_cnt_q == '0);
  assign act_ok_o = (rp_cnt_q == '0) && (rc_cnt_q == '0);

  // checker: cycles since the last ACTIVATE / PRECHARGE, saturating
  logic [GAP_W-1:0] since_act_q, since_pre_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_act_q <= '1;
      since_pre_q <= '1;
    end else begin
      since_act_q <= act_i ? GAP_W'(1) : (since_act_q != '1 ? since_act_q + 1'b1 : since_act_q);
      since_pre_q <= pre_i ? GAP_W'(1) : (since_pre_q != '1 ? since_pre_q + 1'b1 : since_pre_q);
    end
  end

  // R2
  rcd_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> since_act_q >= GAP_W'(T_RCD));
  // R4
  pre_after_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_i |-> open_o && since_act_q >= GAP_W'(T_RCD));
  // R4
  rp_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |-> !open_o && since_pre_q >= GAP_W'(T_RP));
  // R6
  rc_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |-> since_act_q >= GAP_W'(T_RC));
  // R3
  rd_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> open_o && $onehot0({act_i, pre_i, rd_i}));
endmodule

// File: rtl/dram_cmd_picker.sv
// First-ready pick: column commands over row commands, lowest slot (oldest) first.
module dram_cmd_picker
  import dram_sched_pkg::*;
#(
  parameter int DEPTH     = 6,
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 4,
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]                vld_i,
  input  logic [DEPTH-1:0][BANK_W-1:0]    bank_i,
  input  logic [DEPTH-1:0][ROW_W-1:0]     row_i,
  input  logic [NUM_BANKS-1:0]            open_i,
  input  logic [NUM_BANKS-1:0][ROW_W-1:0] open_row_i,
  input  logic [NUM_BANKS-1:0]            col_ok_i,
  input  logic [NUM_BANKS-1:0]            act_ok_i,
  output logic                            valid_o,
  output logic [IDX_W-1:0]                idx_o,
  output cmd_e                            cmd_o
);
  logic [DEPTH-1:0] col_rdy, row_rdy, needs_pre;
  logic             col_any, row_any;
  logic [IDX_W-1:0] col_idx, row_idx;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic hit, opn;
      opn          = open_i[bank_i[i]];
      hit          = opn && (open_row_i[bank_i[i]] == row_i[i]);
      needs_pre[i] = opn && !hit;
      col_rdy[i]   = vld_i[i] && hit && col_ok_i[bank_i[i]];
      row_rdy[i]   = vld_i[i] && (opn ? (!hit && col_ok_i[bank_i[i]]) : act_ok_i[bank_i[i]]);
    end
    col_any = 1'b0;
    row_any = 1'b0;
    col_idx = '0;
    row_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (col_rdy[i]) begin
        col_any = 1'b1;
        col_idx = IDX_W'(i);
      end
      if (row_rdy[i]) begin
        row_any = 1'b1;
        row_idx = IDX_W'(i);
      end
    end
    valid_o = col_any || row_any;
    idx_o   = col_any ? col_idx : row_idx;
    if (col_any)                 cmd_o = CMD_RD;
    else if (!row_any)           cmd_o = CMD_NOP;
    else if (needs_pre[row_idx]) cmd_o = CMD_PRE;
    else                         cmd_o = CMD_ACT;
  end
endmodule

// File: rtl/dram_sched_frfcfs.sv
module dram_sched_frfcfs
  import dram_sched_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 4,
  parameter int COL_W     = 4,
  parameter int ID_W      = 4,
  parameter int QDEPTH    = 6,
  parameter int T_RCD     = 2,
  parameter int T_CL      = 2,
  parameter int T_RP      = 2,
  parameter int T_RC      = 6,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [ID_W-1:0]   req_id_i,
  output logic              req_ready_o,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_type_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]  cmd_row_o,
  output logic [COL_W-1:0]  cmd_col_o,
  output logic              done_valid_o,
  output logic [ID_W-1:0]   done_id_o
);
  localparam int IDX_W = $clog2(QDEPTH);

  logic [QDEPTH-1:0]             q_vld;
  logic [QDEPTH-1:0][BANK_W-1:0] q_bank;
  logic [QDEPTH-1:0][ROW_W-1:0]  q_row;
  logic [QDEPTH-1:0][COL_W-1:0]  q_col;
  logic [QDEPTH-1:0][ID_W-1:0]   q_id;
  logic                          q_full;

  logic [NUM_BANKS-1:0]            bk_open, bk_col_ok, bk_act_ok;
  logic [NUM_BANKS-1:0][ROW_W-1:0] bk_row;

  logic              sel_valid;
  logic [IDX_W-1:0]  sel_idx;
  cmd_e              sel_cmd;
  logic [BANK_W-1:0] sel_bank;
  logic              pop, push;

  assign req_ready_o = !q_full;
  assign push        = req_valid_i && req_ready_o;
  assign pop         = sel_valid && (sel_cmd == CMD_RD);
  assign sel_bank    = q_bank[sel_idx];

  dram_req_queue #(
    .DEPTH(QDEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .ID_W(ID_W)
  ) u_queue (
    .clk_i, .rst_ni,
    .push_i(push), .push_bank_i(req_bank_i), .push_row_i(req_row_i),
    .push_col_i(req_col_i), .push_id_i(req_id_i),
    .pop_i(pop), .pop_idx_i(sel_idx),
    .vld_o(q_vld), .bank_o(q_bank), .row_o(q_row), .col_o(q_col), .id_o(q_id),
    .full_o(q_full)
  );

  dram_cmd_picker #(
    .DEPTH(QDEPTH), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W)
  ) u_picker (
    .vld_i(q_vld), .bank_i(q_bank), .row_i(q_row),
    .open_i(bk_open), .open_row_i(bk_row), .col_ok_i(bk_col_ok), .act_ok_i(bk_act_ok),
    .valid_o(sel_valid), .idx_o(sel_idx), .cmd_o(sel_cmd)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic here;
    assign here = sel_valid && (sel_bank == BANK_W'(b));
    dram_bank_state #(
      .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC)
    ) u_bank (
      .clk_i, .rst_ni,
      .act_i(here && sel_cmd == CMD_ACT),
      .pre_i(here && sel_cmd == CMD_PRE),
      .rd_i (here && sel_cmd == CMD_RD),
      .row_i(q_row[sel_idx]),
      .open_o(bk_open[b]), .row_o(bk_row[b]),
      .col_ok_o(bk_col_ok[b]), .act_ok_o(bk_act_ok[b])
    );
  end

  // command bus register
  logic              cmd_valid_q;
  cmd_e              cmd_type_q;
  logic [BANK_W-1:0] cmd_bank_q;
  logic [ROW_W-1:0]  cmd_row_q;
  logic [COL_W-1:0]  cmd_col_q;
  logic [ID_W-1:0]   cmd_id_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_q <= 1'b0;
      cmd_type_q  <= CMD_NOP;
      cmd_bank_q  <= '0;
      cmd_row_q   <= '0;
      cmd_col_q   <= '0;
      cmd_id_q    <= '0;
    end else begin
      cmd_valid_q <= sel_valid;
      cmd_type_q  <= sel_cmd;
      cmd_bank_q  <= sel_bank;
      cmd_row_q   <= q_row[sel_idx];
      cmd_col_q   <= q_col[sel_idx];
      cmd_id_q    <= q_id[sel_idx];
    end
  end

  assign cmd_valid_o = cmd_valid_q;
  assign cmd_type_o  = cmd_type_q;
  assign cmd_bank_o  = cmd_bank_q;
  assign cmd_row_o   = cmd_row_q;
  assign cmd_col_o   = cmd_col_q;

  // completion delay line, T_CL stages behind the bus
  logic [T_CL-1:0]           dv_q;
  logic [T_CL-1:0][ID_W-1:0] did_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dv_q  <= '0;
      did_q <= '0;
    end else begin
      dv_q[0]  <= cmd_valid_q && (cmd_type_q == CMD_RD);
      did_q[0] <= cmd_id_q;
      for (int k = 1; k < T_CL; k++) begin
        dv_q[k]  <= dv_q[k-1];
        did_q[k] <= did_q[k-1];
      end
    end
  end

  assign done_valid_o = dv_q[T_CL-1];
  assign done_id_o    = did_q[T_CL-1];

  // R9
  nop_type_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_o |-> cmd_type_o == 2'b00);
  // R8
  ready_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && !pop) |=> !req_ready_o);
endmodule

// File: tb/sim_dram_sched_frfcfs.sv
module sim_dram_sched_frfcfs;
  localparam int NB = 4, D = 6, TRCD = 2, TRP = 2, TRC = 6, TCL = 2;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_bank = '0;
  logic [3:0] req_row = '0, req_col = '0, req_id = '0;
  logic       req_ready, cmd_valid, done_valid;
  logic [1:0] cmd_type, cmd_bank;
  logic [3:0] cmd_row, cmd_col, done_id;

  always #10 clk = ~clk;

  dram_sched_frfcfs u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_bank_i(req_bank), .req_row_i(req_row),
    .req_col_i(req_col), .req_id_i(req_id), .req_ready_o(req_ready),
    .cmd_valid_o(cmd_valid), .cmd_type_o(cmd_type), .cmd_bank_o(cmd_bank),
    .cmd_row_o(cmd_row), .cmd_col_o(cmd_col),
    .done_valid_o(done_valid), .done_id_o(done_id)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model (list of pending requests) ----------
  int qn, qb[D], qr[D], qc[D], qi[D];
  int bopen[NB], brow[NB], rd_at[NB], act_at[NB];
  int cyc;
  int exp_cv, exp_ct, exp_cb, exp_cr, exp_cc, exp_cid;
  int dv[TCL], did[TCL];
  int exp_rdy, exp_dv, exp_did;
  int m_sel, m_typ, m_b;
  bit rdy_pre;

  always @(posedge clk) begin
    if (!rst_ni) begin
      qn = 0; cyc = 0;
      for (int b = 0; b < NB; b++) begin bopen[b] = 0; brow[b] = 0; rd_at[b] = 0; act_at[b] = 0; end
      for (int k = 0; k < TCL; k++) begin dv[k] = 0; did[k] = 0; end
      exp_cv = 0; exp_ct = 0; exp_cid = 0; exp_rdy = 1; exp_dv = 0; exp_did = 0;
    end else begin
      cyc++;
      for (int k = TCL - 1; k > 0; k--) begin dv[k] = dv[k-1]; did[k] = did[k-1]; end
      dv[0] = (exp_cv != 0 && exp_ct == 2); did[0] = exp_cid;
      rdy_pre = (qn < D);
      m_sel = -1; m_typ = 0;
      for (int i = 0; i < qn; i++)
        if (m_sel < 0 && bopen[qb[i]] != 0 && brow[qb[i]] == qr[i] && cyc >= rd_at[qb[i]]) begin
          m_sel = i; m_typ = 2;
        end
      if (m_sel < 0)
        for (int i = 0; i < qn; i++)
          if (m_sel < 0) begin
            m_b = qb[i];
            if (bopen[m_b] == 0 && cyc >= act_at[m_b]) begin m_sel = i; m_typ = 1; end
            else if (bopen[m_b] != 0 && brow[m_b] != qr[i] && cyc >= rd_at[m_b]) begin m_sel = i; m_typ = 3; end
          end
      exp_cv = (m_sel >= 0);
      if (m_sel >= 0) begin
        m_b = qb[m_sel];
        exp_ct = m_typ; exp_cb = m_b; exp_cr = qr[m_sel]; exp_cc = qc[m_sel]; exp_cid = qi[m_sel];
        if (m_typ == 1) begin
          bopen[m_b] = 1; brow[m_b] = qr[m_sel]; rd_at[m_b] = cyc + TRCD; act_at[m_b] = cyc + TRC;
        end else if (m_typ == 3) begin
          bopen[m_b] = 0; if (act_at[m_b] < cyc + TRP) act_at[m_b] = cyc + TRP;
        end else begin
          for (int j = m_sel; j < qn - 1; j++) begin
            qb[j] = qb[j+1]; qr[j] = qr[j+1]; qc[j] = qc[j+1]; qi[j] = qi[j+1];
          end
          qn--;
        end
      end else exp_ct = 0;
      if (req_valid && rdy_pre) begin
        qb[qn] = req_bank; qr[qn] = req_row; qc[qn] = req_col; qi[qn] = req_id; qn++;
      end
      exp_rdy = (qn < D);
      exp_dv = dv[TCL-1]; exp_did = did[TCL-1];
    end
  end

  // ---------------- per-cycle compare and port monitors ----------------
  int ncyc = 0, n_act = 0, n_pre = 0, n_rd = 0, n_done = 0, n_acc = 0;
  int last_act[NB], last_pre[NB];
  int any_last_act = -100, any_last_bank = 0;
  bit seen_indep = 0, seen_full = 0;
  int dlog[8192];
  int a_pk, e_pk;

  initial for (int b = 0; b < NB; b++) begin last_act[b] = -100; last_pre[b] = -100; end

  always @(negedge clk) begin
    if (rst_ni) begin
      ncyc++;
      chk(req_ready == exp_rdy[0], "R8 ready", req_ready, exp_rdy);
      if (!req_ready) seen_full = 1;
      if (req_valid && req_ready) n_acc++;
      a_pk = cmd_valid ? {cmd_valid, cmd_type, cmd_bank, cmd_row, cmd_col} : {12'h0, cmd_valid};
      e_pk = exp_cv != 0 ? {1'b1, exp_ct[1:0], exp_cb[1:0], exp_cr[3:0], exp_cc[3:0]} : 0;
      if (!cmd_valid) a_pk = {cmd_type, 1'b0} != 3'b000 ? 32'hdead : 0;
      chk(a_pk == e_pk, "R5 R9 command", a_pk, e_pk);
      a_pk = done_valid ? {1'b1, done_id} : 0;
      e_pk = exp_dv != 0 ? {1'b1, exp_did[3:0]} : 0;
      chk(a_pk == e_pk, "R7 completion", a_pk, e_pk);
      if (done_valid) begin
        if (n_done < 8192) dlog[n_done] = done_id;
        n_done++;
      end
      if (cmd_valid && cmd_type == 2'b01) begin
        n_act++;
        chk(ncyc - last_act[cmd_bank] >= TRC, "R6 act spacing", ncyc - last_act[cmd_bank], TRC);
        chk(ncyc - last_pre[cmd_bank] >= TRP, "R4 pre to act", ncyc - last_pre[cmd_bank], TRP);
        if (any_last_bank != cmd_bank && ncyc - any_last_act < TRC) seen_indep = 1;
        last_act[cmd_bank] = ncyc; any_last_act = ncyc; any_last_bank = cmd_bank;
      end
      if (cmd_valid && cmd_type == 2'b11) begin
        n_pre++;
        last_pre[cmd_bank] = ncyc;
      end
      if (cmd_valid && cmd_type == 2'b10) begin
        n_rd++;
        chk(ncyc - last_act[cmd_bank] >= TRCD, "R2 act to read", ncyc - last_act[cmd_bank], TRCD);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input int b, input int r, input int c, input int id);
    @(negedge clk);
    req_valid = 1'b1; req_bank = 2'(b); req_row = 4'(r); req_col = 4'(c); req_id = 4'(id);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic quiet(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  int a0, p0, d0;

  initial begin
    repeat (3) @(negedge clk);
    chk(!cmd_valid && !done_valid && req_ready, "R1 reset outputs",
        {cmd_valid, done_valid, req_ready}, 3'b001);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!cmd_valid && !done_valid && req_ready, "R1 after reset",
        {cmd_valid, done_valid, req_ready}, 3'b001);

    // closed bank: ACT then READ
    a0 = n_act;
    send(0, 3, 1, 1);
    quiet(20);
    chk(n_act - a0 == 1, "R2 one activate", n_act - a0, 1);

    // row hits: reads only
    a0 = n_act; d0 = n_done;
    send(0, 3, 2, 2); send(0, 3, 3, 3); send(0, 3, 4, 4);
    quiet(20);
    chk(n_act == a0, "R3 no activate on hits", n_act - a0, 0);
    chk(n_done - d0 == 3, "R3 hits complete", n_done - d0, 3);

    // conflict: PRE, ACT, READ
    a0 = n_act; p0 = n_pre;
    send(0, 5, 0, 5);
    quiet(20);
    chk(n_pre - p0 == 1 && n_act - a0 == 1, "R4 conflict sequence",
        (n_pre - p0) * 16 + (n_act - a0), 17);

    // reorder: A(row1) B(row2) C(row1) on bank1 -> A, C, B
    d0 = n_done;
    send(1, 1, 0, 6); send(1, 2, 0, 7); send(1, 1, 1, 8);
    quiet(30);
    chk(dlog[d0] == 6, "R5 first done", dlog[d0], 6);
    chk(dlog[d0+1] == 8, "R5 hit overtakes conflict", dlog[d0+1], 8);
    chk(dlog[d0+2] == 7, "R5 conflict last", dlog[d0+2], 7);

    // overfill with conflicting rows; valid held regardless of ready
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      req_valid = 1'b1; req_bank = 2'd2; req_row = 4'(i % 4); req_col = 4'(i); req_id = 4'(i);
    end
    quiet(150);
    chk(seen_full, "R8 ready drops when full", seen_full, 1);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      req_valid = 1'($urandom % 2);
      req_bank = 2'($urandom % NB); req_row = 4'($urandom % 3);
      req_col = 4'($urandom); req_id = 4'(i);
    end
    quiet(200);
    chk(n_done == n_acc, "R8 completions equal acceptances", n_done, n_acc);
    chk(n_rd == n_acc, "R9 one read per accepted request", n_rd, n_acc);
    chk(seen_indep, "R9 banks activate independently", seen_indep, 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule